// File: doc/BRIEF.md
# Quad-Channel DAC Serial Word Loader

This block is the digital front end of a four-channel, 10-bit digital-to-analog converter. A host sends 16-bit words over a four-wire serial link: an active-low chip select, an active-low frame sync, a serial clock and a data line. Each word names one channel. It also carries that channel's settling-speed choice, its software power-down choice and a 10-bit conversion code. All serial pins pass through two-flop synchronizers into the system clock domain. The serial clock and frame sync are edge-detected there.

Each channel is double-buffered. A finished word lands in that channel's input latch. An active-low load pin controls the copy from the input latches to the output latches, and it copies all channels in the same cycle. The host can hold the load pin high while it writes every channel, then pull it low once so that all outputs move together. An active-low hardware power-down pin forces every channel's power-down flag on, whatever the software settings are. The latched codes are kept while it is low.

Top module: `qdac_loader`

## Requirements
- R1: After reset every channel code reads 0, every speed flag reads 0 (slow) and every power-down flag reads 1.
- R2: A word of 16 bits is sent MSB first. Data is sampled on falling serial clock edges that follow a falling frame-sync edge, with chip select low. Bits [15:14] give the channel (0 = channel 0 … 3 = channel 3) and bits [11:2] give the code. When the word is complete, the code is written to that channel only. The other channels keep their values.
- R3: Word bit [13] is the speed flag of the addressed channel (1 = fast, 0 = slow). It appears on `chanFast` bit `ch`.
- R4: Word bit [12] is the software power-down of the addressed channel (1 = powered down). It appears on `chanPowerDown` bit `ch` while the hardware power-down pin is high.
- R5: While `loadN` is high, none of the output codes or flags change. When `loadN` goes low, every channel copies its pending input latch in the same cycle.
- R6: A frame that is clocked while `csN` is high changes no channel.
- R7: A frame that `csN` ends by rising before the 16th bit changes no channel.
- R8: A falling edge on frame sync in the middle of a frame throws away the partial word. The new frame that it starts is then received normally.
- R9: While `pdN` is low, all four power-down flags read 1 and the codes and speed flags stay as they are. Once `pdN` is high again, each channel shows its software power-down setting again.
- R10: Word bits [1:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset (power-on reset) |
| csN | input | 1 | Serial chip select, active low |
| fsN | input | 1 | Frame sync; a falling edge starts a word |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| din | input | 1 | Serial data, MSB first |
| loadN | input | 1 | Load strobe, active low; input latches are copied to the outputs while low |
| pdN | input | 1 | Hardware power-down, active low |
| dacCodes | output | 40 | Output codes; channel ch is at bits [ch*10 +: 10] |
| chanFast | output | 4 | Per-channel speed flag, 1 = fast |
| chanPowerDown | output | 4 | Per-channel power-down flag, 1 = powered down |

## Verification
The assertions assume that the serial clock runs much slower than the system clock. Each serial-clock level must last at least three system clocks, so that every falling edge is seen exactly once after synchronization. They also assume that data is stable for the whole synchronizer delay around each sampling edge, and that a frame-sync falling edge never arrives in the same synchronized cycle as a serial-clock falling edge. The stimulus holds every serial-clock level for four system clocks. It changes data only while the serial clock is high, and it moves frame sync and chip select only while the serial clock is idle. A near-exhaustive sweep covers every channel with every combination of the two control bits, at the code extremes and at computed mid-range codes, with the ignored bits varied.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // Strobes passed from the serial control to the channel datapath
  typedef struct packed {
    logic shift;   // push bitVal into the word register
    logic bitVal;  // sampled serial bit
    logic commit;  // complete word: write addressed input latch
    logic loadEn;  // synchronized load strobe, active high
    logic hwPd;    // synchronized hardware power-down, active high
  } strobe_t;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= {STAGES{RESET_VAL}};
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
  import qdac_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int ADDR_W = 2,
  parameter int CODE_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    fsN,
  input  logic    sclk,
  input  logic    din,
  input  logic    loadN,
  input  logic    pdN,
  output strobe_t strb
);

  localparam int USED_W = ADDR_W + 2 + CODE_W;
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] USED = CNT_W'(USED_W);

  // order: csN, fsN, sclk, din, loadN, pdN
  logic [5:0] syncOut;
  logic csSync, fsSync, sclkSync, dinSync, loadSync, pdSync;

  qdac_sync #(
    .WIDTH(6),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(6'b110011)
  ) pinSync_i (
    .clk (clk),
    .rstN(rstN),
    .d   ({csN, fsN, sclk, din, loadN, pdN}),
    .q   (syncOut)
  );

  assign {csSync, fsSync, sclkSync, dinSync, loadSync, pdSync} = syncOut;

  logic sclkPrev, fsPrev;
  logic sclkFall, fsFall;
  logic active;
  logic [CNT_W-1:0] bitCount;
  logic frameDone, shiftNow;

  assign sclkFall  = sclkPrev & ~sclkSync;
  assign fsFall    = fsPrev & ~fsSync;
  assign frameDone = active && (bitCount == LAST);
  assign shiftNow  = active && !csSync && !fsFall && sclkFall && (bitCount < LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      fsPrev   <= 1'b1;
      active   <= 1'b0;
      bitCount <= '0;
    end else begin
      sclkPrev <= sclkSync;
      fsPrev   <= fsSync;
      if (csSync) begin
        active   <= 1'b0;
        bitCount <= '0;
      end else if (fsFall) begin
        active   <= 1'b1;
        bitCount <= '0;
      end else if (frameDone) begin
        active <= 1'b0;
      end else if (shiftNow) begin
        bitCount <= bitCount + 1'b1;
      end
    end
  end

  // trailing bits beyond the used field are counted but never stored
  assign strb.shift  = shiftNow && (bitCount < USED);
  assign strb.bitVal = dinSync;
  assign strb.commit = frameDone && !csSync && !fsFall;
  assign strb.loadEn = ~loadSync;
  assign strb.hwPd   = ~pdSync;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (bitCount <= LAST)); // R2
  AST_COMMIT_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !active); // R2
  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> (!active && !strb.commit)); // R6
  AST_CS_RISE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csSync) |=> (bitCount == '0)); // R7

endmodule

// File: rtl/qdac_channel_path.sv
module qdac_channel_path
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  output logic [NUM_CH*CODE_W-1:0] codesFlat,
  output logic [NUM_CH-1:0]        fastOut,
  output logic [NUM_CH-1:0]        pdOut
);

  localparam int USED_W = ADDR_W + 2 + CODE_W;
  localparam int FAST_POS = CODE_W + 1;
  localparam int PD_POS = CODE_W;

  logic [USED_W-1:0] wordReg;
  logic [ADDR_W-1:0] wordAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (strb.shift) begin
      wordReg <= {wordReg[USED_W-2:0], strb.bitVal};
    end
  end

  assign wordAddr = wordReg[USED_W-1 -: ADDR_W];

  logic [NUM_CH-1:0][CODE_W-1:0] inCode, outCode;
  logic [NUM_CH-1:0] inFast, inPd, outFast, outPd;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inCode[ch] <= '0;
        inFast[ch] <= 1'b0;
        inPd[ch]   <= 1'b1;
      end else if (strb.commit && (wordAddr == ADDR_W'(ch))) begin
        inCode[ch] <= wordReg[CODE_W-1:0];
        inFast[ch] <= wordReg[FAST_POS];
        inPd[ch]   <= wordReg[PD_POS];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outCode[ch] <= '0;
        outFast[ch] <= 1'b0;
        outPd[ch]   <= 1'b1;
      end else if (strb.loadEn) begin
        outCode[ch] <= inCode[ch];
        outFast[ch] <= inFast[ch];
        outPd[ch]   <= inPd[ch];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pdOut[ch] <= 1'b1;
      end else begin
        pdOut[ch] <= outPd[ch] | strb.hwPd;
      end
    end

    assign codesFlat[ch*CODE_W +: CODE_W] = outCode[ch];
  end

  assign fastOut = outFast;

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(inCode) && $stable(inFast) && $stable(inPd))); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> ($stable(outCode) && $stable(outFast) && $stable(outPd))); // R5
  AST_HW_PD_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strb.hwPd |=> (&pdOut)); // R9
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> ($countones(inCode ^ $past(inCode)) <= CODE_W)); // R2

endmodule

// File: rtl/qdac_loader.sv
module qdac_loader #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 10,
  parameter int FRAME_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     fsN,
  input  logic                     sclk,
  input  logic                     din,
  input  logic                     loadN,
  input  logic                     pdN,
  output logic [NUM_CH*CODE_W-1:0] dacCodes,
  output logic [NUM_CH-1:0]        chanFast,
  output logic [NUM_CH-1:0]        chanPowerDown
);

  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  qdac_pkg::strobe_t strb;

  qdac_serial_ctrl #(
    .FRAME_W(FRAME_W),
    .ADDR_W(ADDR_W),
    .CODE_W(CODE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .fsN  (fsN),
    .sclk (sclk),
    .din  (din),
    .loadN(loadN),
    .pdN  (pdN),
    .strb (strb)
  );

  qdac_channel_path #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .CODE_W(CODE_W)
  ) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .codesFlat(dacCodes),
    .fastOut  (chanFast),
    .pdOut    (chanPowerDown)
  );

endmodule

// File: tb/qdac_loader_tb.sv
module qdac_loader_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, fsN = 1'b1, sclk = 1'b0, din = 1'b0;
  logic loadN = 1'b0, pdN = 1'b1;
  logic [39:0] dacCodes;
  logic [3:0] chanFast, chanPowerDown;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [9:0] expInCode[4], expOutCode[4];
  logic expInFast[4], expOutFast[4], expInPd[4], expOutPd[4];
  bit hwPdExp = 1'b0;

  always #5 clk = ~clk;

  qdac_loader dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .fsN(fsN), .sclk(sclk), .din(din),
    .loadN(loadN), .pdN(pdN), .dacCodes(dacCodes), .chanFast(chanFast),
    .chanPowerDown(chanPowerDown)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mkWord(input int ch, input bit fast, input bit pd,
                                         input logic [9:0] code, input logic [1:0] junk);
    return {ch[1:0], fast, pd, code, junk};
  endfunction

  // send nBits of word; csLevel is chip select during the frame; keepCs leaves it low
  task automatic sendFrame(input logic [15:0] word, input int nBits, input bit csLevel,
                           input bit keepCs);
    csN = csLevel;
    waitCyc(4);
    fsN = 1'b0;
    waitCyc(4);
    for (int i = 0; i < nBits; i++) begin
      din  = word[15-i];
      sclk = 1'b1;
      waitCyc(4);
      sclk = 1'b0;
      waitCyc(4);
    end
    fsN = 1'b1;
    waitCyc(4);
    if (!keepCs) csN = 1'b1;
    waitCyc(4);
  endtask

  task automatic checkVal(input string req, input string what, input int ch,
                          input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s ch%0d: actual %0h expected %0h", req, what, ch, act, exp);
    end
  endtask

  task automatic checkAll(input string reqCode, input string reqFast, input string reqPd);
    for (int ch = 0; ch < 4; ch++) begin
      checkVal(reqCode, "code", ch, int'(dacCodes[ch*10 +: 10]), int'(expOutCode[ch]));
      checkVal(reqFast, "fast", ch, int'(chanFast[ch]), int'(expOutFast[ch]));
      checkVal(reqPd, "powerdown", ch, int'(chanPowerDown[ch]),
               int'(expOutPd[ch] | hwPdExp));
    end
  endtask

  task automatic writeModel(input int ch, input bit fast, input bit pd, input logic [9:0] code);
    expInCode[ch] = code;
    expInFast[ch] = fast;
    expInPd[ch]   = pd;
  endtask

  task automatic transferModel();
    for (int ch = 0; ch < 4; ch++) begin
      expOutCode[ch] = expInCode[ch];
      expOutFast[ch] = expInFast[ch];
      expOutPd[ch]   = expInPd[ch];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < 4; ch++) begin
      expInCode[ch] = '0; expInFast[ch] = 1'b0; expInPd[ch] = 1'b1;
    end
    transferModel();
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(4);

    // R1: reset state
    checkAll("R1", "R1", "R1");

    // R2 R3 R4 R10: sweep channels, control bits, codes and ignored bits
    for (int ch = 0; ch < 4; ch++) begin
      for (int ctl = 0; ctl < 4; ctl++) begin
        for (int ci = 0; ci < 3; ci++) begin
          logic [9:0] code;
          code = (ci == 0) ? 10'h000 : (ci == 1) ? 10'h3FF
               : 10'((ch * 181 + ctl * 67 + 5) % 1024);
          sendFrame(mkWord(ch, ctl[1], ctl[0], code, 2'(ci + ctl)), 16, 1'b0, 1'b0);
          writeModel(ch, ctl[1], ctl[0], code);
          transferModel();
          waitCyc(4);
          checkAll("R2", "R3", "R4");
        end
      end
    end

    // leave distinct values on each channel, with ignored bits set to 11 (R10)
    for (int ch = 0; ch < 4; ch++) begin
      logic [9:0] code;
      code = 10'(37 + ch * 211);
      sendFrame(mkWord(ch, ch[0], 1'b0, code, 2'b11), 16, 1'b0, 1'b0);
      writeModel(ch, ch[0], 1'b0, code);
    end
    transferModel();
    waitCyc(4);
    checkAll("R10", "R10", "R10");

    // R6: full frame with chip select high
    sendFrame(mkWord(2, 1'b1, 1'b1, 10'h155, 2'b00), 16, 1'b1, 1'b0);
    waitCyc(4);
    checkAll("R6", "R6", "R6");

    // R7: chip select rises after 10 bits
    sendFrame(mkWord(1, 1'b1, 1'b1, 10'h2AA, 2'b00), 10, 1'b0, 1'b0);
    waitCyc(4);
    checkAll("R7", "R7", "R7");

    // R8: partial frame to ch3, then new frame-sync fall starts a frame to ch0
    sendFrame(mkWord(3, 1'b1, 1'b1, 10'h0F0, 2'b00), 7, 1'b0, 1'b1);
    sendFrame(mkWord(0, 1'b1, 1'b0, 10'h1C3, 2'b01), 16, 1'b0, 1'b0);
    writeModel(0, 1'b1, 1'b0, 10'h1C3);
    transferModel();
    waitCyc(4);
    checkAll("R8", "R8", "R8");

    // R5: load held high while all channels are rewritten
    loadN = 1'b1;
    waitCyc(4);
    for (int ch = 0; ch < 4; ch++) begin
      logic [9:0] code;
      code = expOutCode[ch] ^ 10'h2A5;
      sendFrame(mkWord(ch, ~expOutFast[ch], 1'b0, code, 2'b10), 16, 1'b0, 1'b0);
      writeModel(ch, ~expOutFast[ch], 1'b0, code);
    end
    waitCyc(4);
    checkAll("R5", "R5", "R5");
    loadN = 1'b0;
    begin
      int matched;
      matched = 0;
      for (int cyc = 0; cyc < 10; cyc++) begin
        @(negedge clk);
        matched = 0;
        for (int ch = 0; ch < 4; ch++)
          if (dacCodes[ch*10 +: 10] == expInCode[ch]) matched++;
        checks++;
        if (matched != 0 && matched != 4) begin
          errors++;
          $display("FAIL R5 simultaneous update: actual %0d channels expected 0 or 4", matched);
        end
      end
      checkVal("R5", "channels updated", 0, matched, 4);
    end
    transferModel();
    checkAll("R5", "R5", "R5");

    // R9: hardware power-down overrides, codes kept, release restores
    pdN = 1'b0;
    hwPdExp = 1'b1;
    waitCyc(6);
    checkAll("R9", "R9", "R9");
    pdN = 1'b1;
    hwPdExp = 1'b0;
    waitCyc(6);
    checkAll("R9", "R9", "R9");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule